// File: doc/BRIEF.md
# Character LCD Write Controller

This block sits between a host that writes bytes and a character display module of the common parallel kind, which takes four data bits per transfer. After reset it runs the display's power-up start sequence by itself while holding its busy output high. Once that is done it accepts one byte at a time from the host. Each byte comes with a select bit that marks it as a command or as character data. The block then sends the byte as two 4-bit transfers and waits long enough for the display to act on it before it releases busy.

The host side uses full-flag semantics. The host may write whenever busy is low, and the write is a single-cycle strobe that the block captures in that same cycle. Busy stays high for the whole of each transfer and its settle wait, so a host that simply waits for busy to drop can be wired straight to the block. A strobe raised while busy is high is dropped. All timing (enable pulse widths, start-up waits and per-command settle times) is given in ns or µs and turned into clock counts from the clock frequency parameter. The display's read/write line is held low, because the block never reads.

Top module: `charlcd_wr`

## Requirements
- R1: While reset is applied and right after it, busy is 1, lcd_en is 0 and lcd_rw is 0.
- R2: After reset, with lcd_rs = 0, the block sends the nibbles 0x3, 0x3, 0x3 and 0x2 as single transfers. It then sends the bytes 0x28 (0x20 when TWO_LINE = 0), 0x0C, 0x01 and 0x06, each as two transfers.
- R3: The start sequence waits at least T_PWR_US before the first enable pulse, at least T_INIT1_US after the first 0x3, at least T_INIT2_US after the second 0x3 and at least the settle time after every later step. Busy stays high until the whole sequence is complete.
- R4: When busy is 0, a one-cycle high on host_wr captures host_byte and host_is_char in that cycle, and busy is 1 from the next cycle. lcd_en is never high while busy is 0.
- R5: Each accepted byte goes out as two enable pulses, bits [7:4] first and bits [3:0] second, with lcd_rs equal to host_is_char (1 = character data, 0 = command).
- R6: lcd_en stays high for at least EN_HI_NS. Between the two nibbles of a byte it stays low for at least EN_LO_NS. lcd_nib and lcd_rs do not change while lcd_en is high.
- R7: After the second pulse of a byte, the next enable pulse comes no sooner than T_CMD_US later. For a command (lcd_rs = 0) of 0x01, 0x02 or 0x03 it comes no sooner than T_LONG_US later. Busy lasts at least 2 + 2·EN_HI + EN_LO + settle clock cycles from the accepting edge.
- R8: A strobe while busy is 1 (during start-up or during a transfer) produces no enable pulse and leaves the transfer in progress unchanged.
- R9: lcd_rw is 0 at all times.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, frequency given by CLK_KHZ |
| rst_n | input | 1 | Asynchronous active-low reset |
| host_byte | input | 8 | Byte to send to the display |
| host_is_char | input | 1 | 1 = character data, 0 = command; drives lcd_rs |
| host_wr | input | 1 | One-cycle write strobe |
| busy | output | 1 | High whenever a write would not be accepted |
| lcd_nib | output | 4 | Display data nibble |
| lcd_en | output | 1 | Display enable strobe |
| lcd_rs | output | 1 | Display register select |
| lcd_rw | output | 1 | Display read/write, held low |

## Verification
A scoreboard predicts every nibble, with its register-select level and the shortest idle gap allowed before it. It flags any pulse it did not predict. A design that dropped the first 0x3, swapped the nibble order or ran the start sequence too fast would therefore show a wrong value or a short gap. The bench sends commands 0x01 and 0x02 to check that the long settle is applied: a design that decoded only the clear command would release the following pulse about 1600 cycles too early. Strobes are also raised during start-up and in the middle of a transfer. A design that accepted them would emit extra pulses that the scoreboard reports.

// File: rtl/charlcd_pkg.sv
package charlcd_pkg;

   typedef enum logic [1:0] {
      WT_CMD   = 2'd0,
      WT_LONG  = 2'd1,
      WT_INIT1 = 2'd2,
      WT_INIT2 = 2'd3
   } wait_sel_e;

   typedef struct packed {
      logic      rs;
      logic [7:0] val;
      logic      nib_only;
      wait_sel_e wsel;
   } lcd_op_t;

   function automatic int unsigned ns_to_cyc(input int unsigned ns, input int unsigned khz);
      longint unsigned prod;
      prod = 64'(ns) * 64'(khz);
      prod = (prod + 64'd999_999) / 64'd1_000_000;
      if (prod == 64'd0) prod = 64'd1;
      return prod[31:0];
   endfunction

   function automatic int unsigned us_to_cyc(input int unsigned us, input int unsigned khz);
      longint unsigned prod;
      prod = 64'(us) * 64'(khz);
      prod = (prod + 64'd999) / 64'd1000;
      if (prod == 64'd0) prod = 64'd1;
      return prod[31:0];
   endfunction

   function automatic int unsigned max2(input int unsigned a, input int unsigned b);
      return (a > b) ? a : b;
   endfunction

endpackage

// File: rtl/charlcd_timer.sv
module charlcd_timer #(
   parameter int unsigned TW = 16
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          load,
   input  logic [TW-1:0] load_val,
   output logic          zero
);
   logic [TW-1:0] cnt;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)             cnt <= '0;
      else if (load)          cnt <= load_val;
      else if (cnt != '0)     cnt <= cnt - 1'b1;
   end

   assign zero = (cnt == '0);
endmodule

// File: rtl/charlcd_init_rom.sv
module charlcd_init_rom
   import charlcd_pkg::*;
#(
   parameter bit TWO_LINE = 1'b1
) (
   input  logic [2:0] step,
   output lcd_op_t    op,
   output logic       last
);
   localparam logic [7:0] FUNC_SET = TWO_LINE ? 8'h28 : 8'h20;

   always_comb begin
      op.rs       = 1'b0;
      op.val      = 8'h00;
      op.nib_only = 1'b0;
      op.wsel     = WT_CMD;
      unique case (step)
         3'd0: begin op.val = 8'h30; op.nib_only = 1'b1; op.wsel = WT_INIT1; end
         3'd1: begin op.val = 8'h30; op.nib_only = 1'b1; op.wsel = WT_INIT2; end
         3'd2: begin op.val = 8'h30; op.nib_only = 1'b1; end
         3'd3: begin op.val = 8'h20; op.nib_only = 1'b1; end
         3'd4: op.val = FUNC_SET;
         3'd5: op.val = 8'h0C;
         3'd6: begin op.val = 8'h01; op.wsel = WT_LONG; end
         default: op.val = 8'h06;
      endcase
      last = (step == 3'd7);
   end
endmodule

// File: rtl/charlcd_nib_tx.sv
module charlcd_nib_tx
   import charlcd_pkg::*;
#(
   parameter int unsigned TW       = 16,
   parameter int unsigned HI_CYC   = 1,
   parameter int unsigned LO_CYC   = 1,
   parameter int unsigned CMD_CYC  = 40,
   parameter int unsigned LONG_CYC = 1640,
   parameter int unsigned I1_CYC   = 4100,
   parameter int unsigned I2_CYC   = 100,
   parameter bit          OUT_REG  = 1'b1
) (
   input  logic       clk,
   input  logic       rst_n,
   input  logic       start,
   input  lcd_op_t    op,
   output logic       done,
   output logic [3:0] lcd_nib,
   output logic       lcd_en,
   output logic       lcd_rs
);
   localparam logic [TW-1:0] HI_M1   = TW'(HI_CYC - 1);
   localparam logic [TW-1:0] LO_M1   = TW'(LO_CYC - 1);
   localparam logic [TW-1:0] CMD_M1  = TW'(CMD_CYC - 1);
   localparam logic [TW-1:0] LONG_M1 = TW'(LONG_CYC - 1);
   localparam logic [TW-1:0] I1_M1   = TW'(I1_CYC - 1);
   localparam logic [TW-1:0] I2_M1   = TW'(I2_CYC - 1);

   typedef enum logic [2:0] {
      TX_IDLE, TX_SU1, TX_HI1, TX_LO1, TX_SU2, TX_HI2, TX_WAIT
   } tx_st_e;

   tx_st_e        st, nxt;
   lcd_op_t       op_q;
   logic [3:0]    nib_q;
   logic          t_load, t_zero;
   logic [TW-1:0] t_val, wait_m1;
   logic          en_raw;

   charlcd_timer #(.TW(TW)) u_tmr (
      .clk(clk), .rst_n(rst_n), .load(t_load), .load_val(t_val), .zero(t_zero)
   );

   always_comb begin
      unique case (op_q.wsel)
         WT_LONG:  wait_m1 = LONG_M1;
         WT_INIT1: wait_m1 = I1_M1;
         WT_INIT2: wait_m1 = I2_M1;
         default:  wait_m1 = CMD_M1;
      endcase
   end

   always_comb begin
      nxt    = st;
      t_load = 1'b0;
      t_val  = '0;
      done   = 1'b0;
      unique case (st)
         TX_IDLE: if (start) nxt = TX_SU1;
         TX_SU1: begin nxt = TX_HI1; t_load = 1'b1; t_val = HI_M1; end
         TX_HI1: if (t_zero) begin
            t_load = 1'b1;
            if (op_q.nib_only) begin nxt = TX_WAIT; t_val = wait_m1; end
            else               begin nxt = TX_LO1;  t_val = LO_M1;   end
         end
         TX_LO1: if (t_zero) nxt = TX_SU2;
         TX_SU2: begin nxt = TX_HI2; t_load = 1'b1; t_val = HI_M1; end
         TX_HI2: if (t_zero) begin nxt = TX_WAIT; t_load = 1'b1; t_val = wait_m1; end
         TX_WAIT: if (t_zero) begin nxt = TX_IDLE; done = 1'b1; end
         default: nxt = TX_IDLE;
      endcase
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         st    <= TX_IDLE;
         op_q  <= '0;
         nib_q <= 4'h0;
      end else begin
         st <= nxt;
         if (st == TX_IDLE && start) begin
            op_q  <= op;
            nib_q <= op.val[7:4];
         end else if (st == TX_LO1 && t_zero) begin
            nib_q <= op_q.val[3:0];
         end
      end
   end

   assign en_raw = (st == TX_HI1) || (st == TX_HI2);

   generate
      if (OUT_REG) begin : g_oreg
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
               lcd_en  <= 1'b0;
               lcd_rs  <= 1'b0;
               lcd_nib <= 4'h0;
            end else begin
               lcd_en  <= en_raw;
               lcd_rs  <= op_q.rs;
               lcd_nib <= nib_q;
            end
         end
      end else begin : g_ocomb
         always_comb begin
            lcd_en  = en_raw;
            lcd_rs  = op_q.rs;
            lcd_nib = nib_q;
         end
      end
   endgenerate

   logic [TW-1:0] en_hi_cnt;
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)      en_hi_cnt <= '0;
      else if (lcd_en) en_hi_cnt <= en_hi_cnt + 1'b1;
      else             en_hi_cnt <= '0;
   end

   AST_EN_DATA_STABLE: assert property (@(posedge clk) disable iff (!rst_n)
      (lcd_en && $past(lcd_en)) |-> ($stable(lcd_nib) && $stable(lcd_rs))); // R6
   AST_EN_HIGH_WIDTH: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(lcd_en) |-> (en_hi_cnt >= TW'(HI_CYC))); // R6
   AST_START_WHEN_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
      start |-> (st == TX_IDLE)); // R8
endmodule

// File: rtl/charlcd_wr.sv
module charlcd_wr
   import charlcd_pkg::*;
#(
   parameter int unsigned CLK_KHZ    = 50000,
   parameter int unsigned EN_HI_NS   = 500,
   parameter int unsigned EN_LO_NS   = 500,
   parameter int unsigned T_PWR_US   = 15000,
   parameter int unsigned T_INIT1_US = 4100,
   parameter int unsigned T_INIT2_US = 100,
   parameter int unsigned T_CMD_US   = 40,
   parameter int unsigned T_LONG_US  = 1640,
   parameter bit          TWO_LINE   = 1'b1,
   parameter bit          OUT_REG    = 1'b1
) (
   input  logic       clk,
   input  logic       rst_n,
   input  logic [7:0] host_byte,
   input  logic       host_is_char,
   input  logic       host_wr,
   output logic       busy,
   output logic [3:0] lcd_nib,
   output logic       lcd_en,
   output logic       lcd_rs,
   output logic       lcd_rw
);
   localparam int unsigned HI_CYC   = ns_to_cyc(EN_HI_NS, CLK_KHZ);
   localparam int unsigned LO_CYC   = ns_to_cyc(EN_LO_NS, CLK_KHZ);
   localparam int unsigned PWR_CYC  = us_to_cyc(T_PWR_US, CLK_KHZ);
   localparam int unsigned I1_CYC   = us_to_cyc(T_INIT1_US, CLK_KHZ);
   localparam int unsigned I2_CYC   = us_to_cyc(T_INIT2_US, CLK_KHZ);
   localparam int unsigned CMD_CYC  = us_to_cyc(T_CMD_US, CLK_KHZ);
   localparam int unsigned LONG_CYC = us_to_cyc(T_LONG_US, CLK_KHZ);
   localparam int unsigned MAX_CYC  =
      max2(max2(max2(PWR_CYC, I1_CYC), max2(I2_CYC, LONG_CYC)),
           max2(max2(CMD_CYC, HI_CYC), LO_CYC));
   localparam int unsigned TW = $clog2(MAX_CYC + 1) + 1;
   localparam logic [TW-1:0] PWR_M1 = TW'(PWR_CYC - 1);

   generate
      if (CLK_KHZ == 0) begin : g_chk_clk
         $error("charlcd_wr: CLK_KHZ must be nonzero");
      end
      if (T_LONG_US < T_CMD_US) begin : g_chk_long
         $error("charlcd_wr: long settle shorter than standard settle");
      end
      if (T_INIT1_US < T_INIT2_US) begin : g_chk_init
         $error("charlcd_wr: first start-up wait shorter than second");
      end
   endgenerate

   typedef enum logic [2:0] {
      SQ_BOOT, SQ_PWR, SQ_ISSUE, SQ_INIT_WAIT, SQ_IDLE, SQ_XFER
   } sq_st_e;

   sq_st_e     st;
   logic [2:0] step;
   lcd_op_t    rom_op, host_op, tx_op;
   logic       rom_last;
   logic       tx_start, tx_done;
   logic       pwr_load, pwr_zero;
   logic       long_cmd;

   charlcd_init_rom #(.TWO_LINE(TWO_LINE)) u_rom (
      .step(step), .op(rom_op), .last(rom_last)
   );

   charlcd_timer #(.TW(TW)) u_pwr_tmr (
      .clk(clk), .rst_n(rst_n), .load(pwr_load), .load_val(PWR_M1), .zero(pwr_zero)
   );

   assign long_cmd = !host_is_char && (host_byte[7:2] == 6'd0) && (host_byte[1:0] != 2'd0);

   always_comb begin
      host_op.rs       = host_is_char;
      host_op.val      = host_byte;
      host_op.nib_only = 1'b0;
      host_op.wsel     = long_cmd ? WT_LONG : WT_CMD;
   end

   assign tx_op    = (st == SQ_ISSUE) ? rom_op : host_op;
   assign tx_start = (st == SQ_ISSUE) || (st == SQ_IDLE && host_wr);
   assign pwr_load = (st == SQ_BOOT);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         st   <= SQ_BOOT;
         step <= 3'd0;
      end else begin
         unique case (st)
            SQ_BOOT:      st <= SQ_PWR;
            SQ_PWR:       if (pwr_zero) st <= SQ_ISSUE;
            SQ_ISSUE:     st <= SQ_INIT_WAIT;
            SQ_INIT_WAIT: if (tx_done) begin
               if (rom_last) st <= SQ_IDLE;
               else begin
                  step <= step + 3'd1;
                  st   <= SQ_ISSUE;
               end
            end
            SQ_IDLE:      if (host_wr) st <= SQ_XFER;
            SQ_XFER:      if (tx_done) st <= SQ_IDLE;
            default:      st <= SQ_BOOT;
         endcase
      end
   end

   assign busy   = (st != SQ_IDLE);
   assign lcd_rw = 1'b0;

   charlcd_nib_tx #(
      .TW(TW), .HI_CYC(HI_CYC), .LO_CYC(LO_CYC), .CMD_CYC(CMD_CYC),
      .LONG_CYC(LONG_CYC), .I1_CYC(I1_CYC), .I2_CYC(I2_CYC), .OUT_REG(OUT_REG)
   ) u_tx (
      .clk(clk), .rst_n(rst_n), .start(tx_start), .op(tx_op), .done(tx_done),
      .lcd_nib(lcd_nib), .lcd_en(lcd_en), .lcd_rs(lcd_rs)
   );

   AST_EN_UNDER_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
      lcd_en |-> busy); // R4
   AST_TAKE_RAISES_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
      (!busy && host_wr) |=> busy); // R4
endmodule

// File: tb/charlcd_wr_bench.sv
module charlcd_wr_bench;
   localparam int KHZ  = 1000;
   localparam int EH   = 1;
   localparam int EL   = 1;
   localparam int PWR  = 15000;
   localparam int I1   = 4100;
   localparam int I2   = 100;
   localparam int CMD  = 40;
   localparam int LONG = 1640;

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic [7:0] host_byte = 8'h00;
   logic       host_is_char = 1'b0;
   logic       host_wr = 1'b0;
   logic       busy, lcd_en, lcd_rs, lcd_rw;
   logic [3:0] lcd_nib;

   always #2 clk = ~clk;

   charlcd_wr #(.CLK_KHZ(KHZ)) u_charlcd_wr (
      .clk(clk), .rst_n(rst_n), .host_byte(host_byte), .host_is_char(host_is_char),
      .host_wr(host_wr), .busy(busy), .lcd_nib(lcd_nib), .lcd_en(lcd_en),
      .lcd_rs(lcd_rs), .lcd_rw(lcd_rw)
   );

   typedef struct {
      bit       rs;
      bit [3:0] nib;
      int       min_gap;
      string    tag;
   } exp_t;

   exp_t q[$];
   int   total = 0;
   int   bad = 0;
   int   next_gap = CMD;
   int   rw_bad = 0;
   bit   done_flag = 1'b0;

   task automatic check(input bit ok, input string tag, input string what,
                        input int act, input int expv);
      total++;
      if (!ok) begin
         bad++;
         $display("FAIL %s %s actual=%0d expected=%0d", tag, what, act, expv);
      end
   endtask

   task automatic push_nib(input bit rs, input bit [3:0] n, input int g, input string tag);
      exp_t e;
      e.rs = rs; e.nib = n; e.min_gap = g; e.tag = tag;
      q.push_back(e);
   endtask

   // monitor: compares every enable pulse against the scoreboard queue
   bit en_prev = 1'b0;
   int gap = 0;
   int hi_len = 0;
   always @(negedge clk) begin
      if (rst_n) begin
         if (lcd_rw !== 1'b0) rw_bad++;
         if (lcd_en && !en_prev) begin
            if (q.size() == 0) begin
               check(1'b0, "R8", "unexpected enable pulse nib", int'(lcd_nib), -1);
            end else begin
               exp_t e;
               e = q.pop_front();
               check(lcd_nib == e.nib, e.tag, "nibble", int'(lcd_nib), int'(e.nib));
               check(lcd_rs == e.rs, e.tag, "register select", int'(lcd_rs), int'(e.rs));
               check(gap >= e.min_gap, (e.min_gap >= CMD) ? "R7/R3" : "R6",
                     "low gap before pulse", gap, e.min_gap);
            end
            hi_len = 1;
         end else if (lcd_en) begin
            hi_len++;
         end
         if (!lcd_en && en_prev) check(hi_len >= EH, "R6", "enable high width", hi_len, EH);
         if (!lcd_en) gap++; else gap = 0;
         en_prev = lcd_en;
      end
   end

   task automatic push_byte(input bit rs, input bit [7:0] b, input int g, input string tag);
      push_nib(rs, b[7:4], g, tag);
      push_nib(rs, b[3:0], EL, tag);
   endtask

   task automatic send(input bit is_char, input bit [7:0] b, input bit inject);
      int  cnt;
      bit  lng;
      lng = !is_char && (b == 8'h01 || b == 8'h02 || b == 8'h03);
      while (busy) @(negedge clk);
      push_byte(is_char, b, next_gap, "R5");
      host_byte = b; host_is_char = is_char; host_wr = 1'b1;
      @(negedge clk);
      host_wr = 1'b0;
      check(busy == 1'b1, "R4", "busy after accepted strobe", int'(busy), 1);
      cnt = 1;
      if (inject) begin
         repeat (2) begin @(negedge clk); cnt++; end
         host_byte = 8'hFF; host_is_char = 1'b1; host_wr = 1'b1;
         @(negedge clk); cnt++;
         host_wr = 1'b0;
         check(busy == 1'b1, "R8", "busy held across ignored strobe", int'(busy), 1);
      end
      while (busy) begin @(negedge clk); if (busy) cnt++; end
      check(cnt >= 2 + 2*EH + EL + (lng ? LONG : CMD), "R7", "busy length in cycles",
            cnt, 2 + 2*EH + EL + (lng ? LONG : CMD));
      next_gap = lng ? LONG : CMD;
   endtask

   initial begin
      int elapsed;
      repeat (5) @(negedge clk);
      check(busy == 1'b1, "R1", "busy during reset", int'(busy), 1);
      check(lcd_en == 1'b0, "R1", "enable during reset", int'(lcd_en), 0);
      check(lcd_rw == 1'b0, "R1", "rw during reset", int'(lcd_rw), 0);
      // expected start-up sequence (R2), with its minimum waits (R3)
      push_nib(1'b0, 4'h3, PWR, "R2");
      push_nib(1'b0, 4'h3, I1, "R2");
      push_nib(1'b0, 4'h3, I2, "R2");
      push_nib(1'b0, 4'h2, CMD, "R2");
      push_byte(1'b0, 8'h28, CMD, "R2");
      push_byte(1'b0, 8'h0C, CMD, "R2");
      push_byte(1'b0, 8'h01, CMD, "R2");
      push_byte(1'b0, 8'h06, LONG, "R2");
      rst_n = 1'b1;
      @(negedge clk);
      check(busy == 1'b1, "R1", "busy right after reset", int'(busy), 1);
      check(lcd_en == 1'b0, "R1", "enable right after reset", int'(lcd_en), 0);
      elapsed = 1;
      repeat (300) begin @(negedge clk); elapsed++; end
      host_byte = 8'h55; host_is_char = 1'b1; host_wr = 1'b1;   // R8 strobe during start-up
      @(negedge clk); elapsed++;
      host_wr = 1'b0;
      check(busy == 1'b1, "R8", "busy across strobe in start-up", int'(busy), 1);
      while (busy) begin @(negedge clk); elapsed++; end
      check(elapsed >= PWR + I1 + I2 + 5*CMD + LONG, "R3", "start-up busy length",
            elapsed, PWR + I1 + I2 + 5*CMD + LONG);
      check(q.size() == 0, "R2", "start-up nibbles left unseen", q.size(), 0);
      next_gap = CMD;
      send(1'b1, 8'h41, 1'b0);
      send(1'b0, 8'h80, 1'b0);
      send(1'b1, 8'hA5, 1'b1);
      send(1'b0, 8'h01, 1'b0);
      send(1'b1, 8'h3C, 1'b0);
      send(1'b0, 8'h02, 1'b1);
      send(1'b1, 8'h7E, 1'b0);
      send(1'b0, 8'h0F, 1'b0);
      repeat (20) @(negedge clk);
      check(q.size() == 0, "R8", "scoreboard items left", q.size(), 0);
      check(rw_bad == 0, "R9", "cycles with rw high", rw_bad, 0);
      check(lcd_en == 1'b0 && busy == 1'b0, "R4", "quiet when idle",
            int'({lcd_en, busy}), 0);
      done_flag = 1'b1;
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
   end

   initial begin
      repeat (150000) @(posedge clk);
      if (!done_flag) begin
         total++;
         bad++;
         $display("FAIL watchdog (R1..all) actual=hung expected=finished");
         $display("test done: total=%0d bad=%0d", total, bad);
         $finish;
      end
   end
endmodule